// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent 32-bit down-counters behind a 16-bit register bus. Each channel has its own count register, a reload constant and a control word. The control word selects the count clock, starts and stops counting, enables the interrupt and holds a sticky underflow flag. The count clock is one of five taps of a shared prescaler or an edge of one external clock pin. When a running counter steps below zero, the channel reloads from its constant in that same cycle, raises its flag and keeps counting.

The bus carries only 16 bits, so reading a count takes two accesses. Reading the upper half first latches the whole 32-bit count into a per-channel holding buffer, and the later lower-half read returns the buffered value. Both halves therefore come from one instant. Channel 2 also has a read-only capture register. On a chosen edge of the synchronized external pin it takes a copy of the channel 2 count. Reset does not clear the channel 2 count.

Top module: `triple_reload_timer`

## Requirements
- R1: After reset, the channel 0 and channel 1 counts and every reload constant read 0xFFFFFFFF. Every control word reads 0, `irq` is 0 and `bus_rdata` is 0. The channel 2 count is left uncleared.
- R2: The register address is {channel[1:0], offset[2:0]}. The offsets are: 0 control, 1 constant low, 2 constant high, 3 count high (this read latches all 32 bits), 4 count low (from the latch), 5 capture high, 6 capture low. The control word bits are: [2:0] clock select, [3] start, [4] interrupt enable, [5] underflow flag, [7:6] capture edge, [8] capture enable. With start set, clock select 0 to 4 decrements the count exactly once every 4, 16, 64, 256 and 1024 clocks respectively.
- R3: When a counting step finds the count at 0, the count takes the reload constant on that clock, flag bit 5 is set, and later steps decrement from the reloaded value.
- R4: A count-high read captures the full count in a holding buffer. A later count-low read of the same channel returns the low half of that captured value, however many steps have passed since.
- R5: The flag stays set until a control write with bit 5 = 0. A control write with bit 5 = 1 leaves the flag unchanged. If a clearing write and an underflow fall on the same clock, the flag ends up set.
- R6: With start = 0 the count does not change. A bus write to either count half takes effect on that clock and overrides both the decrement and the reload.
- R7: `irq[n]` is 1 exactly when channel n has both its flag and its interrupt enable set.
- R8: For channel 2 with capture enable = 1, capture edge 00 captures on rising pin edges, 01 on falling edges, and 10 or 11 on both. The capture register then takes the count present on that clock. With capture enable = 0 nothing is captured. The capture registers of channels 0 and 1 read 0, and their capture enable bit reads back 0.
- R9: Clock select 5, 6 and 7 decrement once per rising, falling, or either edge of `ext_clk_pin`. The pin passes through two synchronizer flops before edge detection.
- R10: `bus_rdata` shows the addressed register on the clock after `bus_rd` and holds its value while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 5 | {channel, register offset} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_clk_pin | input | 1 | Asynchronous external clock / capture pin |
| irq | output | 3 | Per-channel interrupt request |

## Verification
Most wrong internal state in this block shows up in a count read. A prescaler tap or edge decoder that fires at the wrong rate changes the difference between two coherent reads taken a fixed number of clocks apart. A flag or reload fault shows in the next control or count read, and the interrupt output shows a flag fault on the clock after the write. A holding buffer that is not loaded at the upper-half read, or a capture that fires on the wrong edge, is visible through the lower-half or capture read about five clocks after the pin changes. The checks therefore use exact clock counts between reads rather than tolerances.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    OFS_CTRL     = 3'd0,
    OFS_CONST_LO = 3'd1,
    OFS_CONST_HI = 3'd2,
    OFS_CNT_HI   = 3'd3,
    OFS_CNT_LO   = 3'd4,
    OFS_CAP_HI   = 3'd5,
    OFS_CAP_LO   = 3'd6
  } reg_ofs_e;

  localparam logic [2:0] SEL_PIN_RISE = 3'd5;
  localparam logic [2:0] SEL_PIN_FALL = 3'd6;
  localparam logic [2:0] SEL_PIN_BOTH = 3'd7;

  typedef struct packed {
    logic       cap_en;
    logic [1:0] edge_sel;
    logic       flag;
    logic       irq_en;
    logic       start;
    logic [2:0] sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int N_DIV = 5,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [N_DIV-1:0] tick
);
  localparam int PW = N_DIV * STEP;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0]    div_q;
  logic [N_DIV-1:0] tick_nxt;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + ONE;
  end

  // Tap i fires when the low STEP*(i+1) bits are all ones: period 2^(STEP*(i+1))
  for (genvar i = 0; i < N_DIV; i++) begin : g_tap
    assign tick_nxt[i] = &div_q[STEP*(i+1)-1:0];
    if (i > 0) begin : g_nest
      AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
        tick[i] |-> tick[0]);  // R2
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick_nxt;
  end

  AST_TAP0_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick[0] |=> !tick[0]);  // R2

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_N:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_N-1:0], pin};
      rise <= sh[SYNC_N-1] & ~sh[SYNC_N];
      fall <= ~sh[SYNC_N-1] & sh[SYNC_N];
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);  // R9
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);  // R9

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int N_DIV      = 5,
  parameter bit HAS_CAP    = 1'b0,
  parameter bit CLR_ON_RST = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_DIV-1:0]   presc_tick,
  input  logic               pin_rise,
  input  logic               pin_fall,
  input  logic               wr_ctrl,
  input  logic               wr_const_lo,
  input  logic               wr_const_hi,
  input  logic               wr_cnt_lo,
  input  logic               wr_cnt_hi,
  input  logic               rd_latch,
  input  logic [BUS_W-1:0]   wdata,
  output ctrl_t              ctrl_q,
  output logic [2*BUS_W-1:0] const_q,
  output logic [2*BUS_W-1:0] cnt_q,
  output logic [2*BUS_W-1:0] cnt_buf,
  output logic [2*BUS_W-1:0] cap_q,
  output logic               irq
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctrl_t            wr_fields;
  logic             sel_tick, step, at_zero, cnt_wr, unf_evt;
  logic [CNT_W-1:0] cnt_nxt;

  assign wr_fields = ctrl_t'(wdata[CTRL_W-1:0]);

  always_comb begin
    case (ctrl_q.sel)
      SEL_PIN_RISE: sel_tick = pin_rise;
      SEL_PIN_FALL: sel_tick = pin_fall;
      SEL_PIN_BOTH: sel_tick = pin_rise | pin_fall;
      default:      sel_tick = (int'(ctrl_q.sel) < N_DIV) ? presc_tick[ctrl_q.sel] : 1'b0;
    endcase
  end

  assign step    = ctrl_q.start & sel_tick;
  assign at_zero = (cnt_q == '0);
  assign cnt_wr  = wr_cnt_lo | wr_cnt_hi;
  assign unf_evt = step & at_zero & ~cnt_wr;

  always_comb begin
    if (wr_cnt_hi)      cnt_nxt = {wdata, cnt_q[BUS_W-1:0]};
    else if (wr_cnt_lo) cnt_nxt = {cnt_q[CNT_W-1:BUS_W], wdata};
    else if (step)      cnt_nxt = at_zero ? const_q : (cnt_q - ONE);
    else                cnt_nxt = cnt_q;
  end

  if (CLR_ON_RST) begin : g_cnt_rst
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '1;
      else     cnt_q <= cnt_nxt;
    end
  end else begin : g_cnt_keep
    always_ff @(posedge clk) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.sel      <= wr_fields.sel;
      ctrl_q.start    <= wr_fields.start;
      ctrl_q.irq_en   <= wr_fields.irq_en;
      ctrl_q.edge_sel <= wr_fields.edge_sel;
      ctrl_q.cap_en   <= HAS_CAP ? wr_fields.cap_en : 1'b0;
      ctrl_q.flag     <= (ctrl_q.flag & wr_fields.flag) | unf_evt;
    end else begin
      ctrl_q.flag     <= ctrl_q.flag | unf_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      const_q <= '1;
    end else begin
      if (wr_const_lo) const_q[BUS_W-1:0]     <= wdata;
      if (wr_const_hi) const_q[CNT_W-1:BUS_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_buf <= '0;
    else if (rd_latch) cnt_buf <= cnt_q;
  end

  assign irq = ctrl_q.flag & ctrl_q.irq_en;

  if (HAS_CAP) begin : g_cap
    logic edge_hit, cap_evt;
    always_comb begin
      case (ctrl_q.edge_sel)
        2'b00:   edge_hit = pin_rise;
        2'b01:   edge_hit = pin_fall;
        default: edge_hit = pin_rise | pin_fall;
      endcase
    end
    assign cap_evt = ctrl_q.cap_en & edge_hit;

    always_ff @(posedge clk) begin
      if (rst)          cap_q <= '0;
      else if (cap_evt) cap_q <= cnt_q;
    end

    AST_CAPTURE_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
      cap_evt |=> cap_q == $past(cnt_q));  // R8
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !cap_evt |=> $stable(cap_q));  // R8
  end else begin : g_nocap
    assign cap_q = '0;
  end

  AST_RELOAD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step && at_zero && !cnt_wr) |=> (cnt_q == $past(const_q)) && ctrl_q.flag);  // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.flag && !wr_ctrl) |=> ctrl_q.flag);  // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata[5] && !(step && at_zero && !cnt_wr)) |=> !ctrl_q.flag);  // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.start && !cnt_wr) |=> $stable(cnt_q));  // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt_lo && !wr_cnt_hi) |=> cnt_q[BUS_W-1:0] == $past(wdata));  // R6
  AST_BUFFER_COHERENT: assert property (@(posedge clk) disable iff (rst)
    rd_latch |=> cnt_buf == $past(cnt_q));  // R4

endmodule

// File: rtl/triple_reload_timer.sv
module triple_reload_timer
  import tmr_pkg::*;
#(
  parameter int N_CH     = 3,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 5,
  parameter int CAP_CH   = 2,
  parameter int N_DIV    = 5,
  parameter int DIV_STEP = 2,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_clk_pin,
  output logic [N_CH-1:0]   irq
);
  localparam int CNT_W = 2 * BUS_W;
  localparam int CH_W  = ADDR_W - 3;

  logic [CH_W-1:0]  ch_idx;
  reg_ofs_e         ofs;
  logic [N_DIV-1:0] presc_tick;
  logic             pin_rise, pin_fall;
  logic [BUS_W-1:0] rd_word;

  ctrl_t            ctrl_a  [N_CH];
  logic [CNT_W-1:0] const_a [N_CH];
  logic [CNT_W-1:0] cnt_a   [N_CH];
  logic [CNT_W-1:0] buf_a   [N_CH];
  logic [CNT_W-1:0] cap_a   [N_CH];

  assign ch_idx = bus_addr[ADDR_W-1:3];
  assign ofs    = reg_ofs_e'(bus_addr[2:0]);

  tmr_prescaler #(.N_DIV(N_DIV), .STEP(DIV_STEP)) u_presc (
    .clk (clk), .rst (rst), .tick (presc_tick)
  );

  tmr_pin_edge #(.SYNC_N(SYNC_N)) u_pin (
    .clk (clk), .rst (rst), .pin (ext_clk_pin), .rise (pin_rise), .fall (pin_fall)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit = (ch_idx == CH_W'(i));

    tmr_channel #(
      .BUS_W      (BUS_W),
      .N_DIV      (N_DIV),
      .HAS_CAP    (i == CAP_CH),
      .CLR_ON_RST (i != CAP_CH)
    ) u_chan (
      .clk         (clk),
      .rst         (rst),
      .presc_tick  (presc_tick),
      .pin_rise    (pin_rise),
      .pin_fall    (pin_fall),
      .wr_ctrl     (bus_wr & hit & (ofs == OFS_CTRL)),
      .wr_const_lo (bus_wr & hit & (ofs == OFS_CONST_LO)),
      .wr_const_hi (bus_wr & hit & (ofs == OFS_CONST_HI)),
      .wr_cnt_lo   (bus_wr & hit & (ofs == OFS_CNT_LO)),
      .wr_cnt_hi   (bus_wr & hit & (ofs == OFS_CNT_HI)),
      .rd_latch    (bus_rd & hit & (ofs == OFS_CNT_HI)),
      .wdata       (bus_wdata),
      .ctrl_q      (ctrl_a[i]),
      .const_q     (const_a[i]),
      .cnt_q       (cnt_a[i]),
      .cnt_buf     (buf_a[i]),
      .cap_q       (cap_a[i]),
      .irq         (irq[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_idx == CH_W'(i)) begin
        case (ofs)
          OFS_CTRL:     rd_word = BUS_W'(ctrl_a[i]);
          OFS_CONST_LO: rd_word = const_a[i][BUS_W-1:0];
          OFS_CONST_HI: rd_word = const_a[i][CNT_W-1:BUS_W];
          OFS_CNT_HI:   rd_word = cnt_a[i][CNT_W-1:BUS_W];
          OFS_CNT_LO:   rd_word = buf_a[i][BUS_W-1:0];
          OFS_CAP_HI:   rd_word = cap_a[i][CNT_W-1:BUS_W];
          OFS_CAP_LO:   rd_word = cap_a[i][BUS_W-1:0];
          default:      rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));  // R10

endmodule

// File: tb/triple_reload_timer_test.sv
module triple_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk_pin = 1'b0;
  logic [2:0]  irq;

  int n_cmp = 0, n_bad = 0;

  typedef struct { bit chk; logic [15:0] exp; string tag; } item_t;
  item_t       exp_q[$];
  logic        rd_d = 1'b0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  triple_reload_timer uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_pin(ext_clk_pin), .irq(irq)
  );

  // Monitor: data read at one posedge is compared at the following negedge (R10)
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin : mon
    item_t it;
    if (rd_d) begin
      it = exp_q.pop_front();
      last_rd = bus_rdata;
      if (it.chk) begin
        n_cmp++;
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [4:0] ad(int ch, int ofs);
    return {2'(ch), 3'(ofs)};
  endfunction

  function automatic logic [15:0] cw(int sel, bit st, bit ien, bit flg, int edg, bit cap);
    return {7'b0, cap, 2'(edg), flg, ien, st, 3'(sel)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr32(int ch, logic [31:0] v);
    wr(ad(ch, 3), v[31:16]);
    wr(ad(ch, 4), v[15:0]);
  endtask

  task automatic rd(logic [4:0] a, bit chk, logic [15:0] e, string tag, output logic [15:0] v);
    item_t it;
    it.chk = chk; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    #1 v = last_rd;
  endtask

  task automatic rdc(logic [4:0] a, logic [15:0] e, string tag);
    logic [15:0] v;
    rd(a, 1'b1, e, tag, v);
  endtask

  // Coherent 32-bit read; the value is latched at the first posedge, the task spans 4 negedges
  task automatic rd32(int ch, int ofs_hi, output logic [31:0] v);
    logic [15:0] h, l;
    rd(ad(ch, ofs_hi), 1'b0, '0, "", h);
    rd(ad(ch, ofs_hi + 1), 1'b0, '0, "", l);
    v = {h, l};
  endtask

  task automatic rdc32(int ch, int ofs_hi, logic [31:0] e, string tag);
    rdc(ad(ch, ofs_hi), e[31:16], tag);
    rdc(ad(ch, ofs_hi + 1), e[15:0], tag);
  endtask

  task automatic pin_set(logic v);
    @(negedge clk); ext_clk_pin = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic pin_pulse(int n);
    for (int k = 0; k < n; k++) begin
      pin_set(1'b1);
      pin_set(1'b0);
    end
  endtask

  task automatic rate_check(int d, int k, string tag);
    logic [31:0] a, b;
    rd32(0, 3, a);
    repeat (d * k - 4) @(negedge clk);
    rd32(0, 3, b);
    check(tag, a - b, 32'(k));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [15:0] h;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 rdata after reset", 32'(bus_rdata), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
    rdc32(0, 3, 32'hFFFF_FFFF, "R1 ch0 count");
    rdc32(1, 3, 32'hFFFF_FFFF, "R1 ch1 count");
    rdc(ad(1, 2), 16'hFFFF, "R1 ch1 const hi");
    rdc(ad(1, 1), 16'hFFFF, "R1 ch1 const lo");
    rdc(ad(2, 0), 16'h0000, "R1 ch2 ctrl");

    // R2: prescaler rates
    wr(ad(0, 0), cw(0, 1, 0, 0, 0, 0));
    rate_check(4, 10, "R2 div4");
    wr(ad(0, 0), cw(2, 1, 0, 0, 0, 0));
    rate_check(64, 3, "R2 div64");
    wr(ad(0, 0), cw(4, 1, 0, 0, 0, 0));
    rate_check(1024, 2, "R2 div1024");

    // R4: latched low half returned after the count moved on
    wr(ad(0, 0), cw(0, 1, 0, 0, 0, 0));
    rd32(0, 3, v);
    repeat (4) @(negedge clk);
    rd(ad(0, 3), 1'b0, '0, "", h);
    repeat (40) @(negedge clk);
    v = v - 32'd2;
    check("R4 latched hi", 32'(h), 32'(v[31:16]));
    rdc(ad(0, 4), v[15:0], "R4 latched lo");
    // R10: read data holds without a read strobe
    repeat (5) @(negedge clk);
    check("R10 rdata hold", 32'(bus_rdata), 32'(v[15:0]));

    // R9: external pin clocks on channel 1
    wr(ad(1, 0), cw(5, 0, 0, 0, 0, 0));
    wr32(1, 32'd100);
    wr(ad(1, 0), cw(5, 1, 0, 0, 0, 0));
    pin_pulse(3);
    rdc32(1, 3, 32'd97, "R9 rising edges");
    wr(ad(1, 0), cw(6, 1, 0, 0, 0, 0));
    pin_pulse(2);
    rdc32(1, 3, 32'd95, "R9 falling edges");
    wr(ad(1, 0), cw(7, 1, 0, 0, 0, 0));
    pin_pulse(2);
    rdc32(1, 3, 32'd91, "R9 both edges");

    // R3: underflow reloads and sets the flag
    wr(ad(1, 0), cw(5, 1, 0, 0, 0, 0));
    wr(ad(1, 2), 16'h0000);
    wr(ad(1, 1), 16'h0040);
    wr32(1, 32'd1);
    pin_pulse(1);
    rdc(ad(1, 0), cw(5, 1, 0, 0, 0, 0), "R3 no flag before underflow");
    pin_pulse(1);
    rdc32(1, 3, 32'h40, "R3 reloaded count");
    rdc(ad(1, 0), cw(5, 1, 0, 1, 0, 0), "R3 flag set");
    pin_pulse(1);
    rdc32(1, 3, 32'h3F, "R3 counting from reload");

    // R7 / R5: interrupt gating and flag write rules
    check("R7 irq masked", 32'(irq[1]), 32'h0);
    wr(ad(1, 0), cw(5, 1, 1, 1, 0, 0));
    check("R7 irq raised", 32'(irq[1]), 32'h1);
    rdc(ad(1, 0), cw(5, 1, 1, 1, 0, 0), "R5 write one keeps flag");
    wr(ad(1, 0), cw(5, 1, 1, 0, 0, 0));
    check("R7 irq after clear", 32'(irq[1]), 32'h0);
    rdc(ad(1, 0), cw(5, 1, 1, 0, 0, 0), "R5 write zero clears");

    // R5: clearing write on the same clock as an underflow
    wr(ad(1, 4), 16'h0000);
    @(negedge clk); ext_clk_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(ad(1, 0), cw(5, 1, 1, 0, 0, 0));
    rdc(ad(1, 0), cw(5, 1, 1, 1, 0, 0), "R5 underflow beats clear");
    rdc32(1, 3, 32'h40, "R5 reload on collision");
    check("R7 irq on collision", 32'(irq[1]), 32'h1);
    pin_set(1'b0);

    // R6: count write beats a decrement on the same clock, start gates counting
    @(negedge clk); ext_clk_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(ad(1, 4), 16'h0777);
    rdc32(1, 3, 32'h777, "R6 write wins over step");
    pin_set(1'b0);
    wr(ad(1, 0), cw(5, 0, 0, 1, 0, 0));
    pin_pulse(2);
    rdc32(1, 3, 32'h777, "R6 stopped holds");

    // R8: channel 2 capture edges
    wr(ad(2, 0), cw(0, 0, 0, 0, 0, 1));
    wr32(2, 32'h1234_5678);
    pin_set(1'b1);
    rdc32(2, 5, 32'h1234_5678, "R8 capture on rise");
    wr32(2, 32'h0000_AAAA);
    pin_set(1'b0);
    rdc32(2, 5, 32'h1234_5678, "R8 fall ignored in rise mode");
    wr(ad(2, 0), cw(0, 0, 0, 0, 1, 1));
    wr32(2, 32'h0000_BBBB);
    pin_set(1'b1);
    rdc32(2, 5, 32'h1234_5678, "R8 rise ignored in fall mode");
    pin_set(1'b0);
    rdc32(2, 5, 32'h0000_BBBB, "R8 capture on fall");
    wr(ad(2, 0), cw(0, 0, 0, 0, 2, 1));
    wr32(2, 32'h0000_CCCC);
    pin_set(1'b1);
    rdc32(2, 5, 32'h0000_CCCC, "R8 capture both rise");
    wr(ad(2, 0), cw(0, 0, 0, 0, 2, 0));
    wr32(2, 32'h0000_DDDD);
    pin_set(1'b0);
    rdc32(2, 5, 32'h0000_CCCC, "R8 capture disabled");
    rdc32(0, 5, 32'h0, "R8 ch0 capture reads zero");
    wr(ad(0, 0), cw(0, 0, 0, 0, 0, 1));
    rdc(ad(0, 0), cw(0, 0, 0, 0, 0, 0), "R8 ch0 capture enable ignored");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule